// File: doc/BRIEF.md
# Board Reset and Firmware Download Sequencer

This block is a host-side controller that brings a multiport serial board from reset to running firmware over the board's byte-wide host register interface. When `start` is pulsed, it writes twice to the board's reset address, with a fixed number of millisecond ticks between the two writes. The gap lets the board's short reset pulse take effect before the second reset. It then collects the 16-byte power-on message from the board's data port and stops at once if either identity byte is wrong.

After the message, the block takes firmware bytes from a simple valid/ready byte stream and writes them to the data port in fixed-size blocks. The first byte of the first block must be a header marker. The second byte of the first block tells the block how many further blocks follow. Once the last byte is written, the block waits for a one-byte verdict from the board and decodes it.

Every data-port access is preceded by a status read, and the access is made only when the relevant status bit allows it. Each phase has its own deadline, counted in `ms_tick` pulses. The first firmware block gets a longer deadline than the later ones. Any failure ends the run with a phase-specific code, and the block makes no further bus accesses.

Top module: `board_boot_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `bus_rd`, `bus_wr`, `done`, `error` and `fw_ready` are 0 and `err_code` is 0.
- R2: A `start` pulse in the idle or finished state causes a write to address 7, then a wait of GAP_MS ticks counted after that write completes, then a second write to address 7. The written data carries no meaning.
- R3: Each data-port read (address 0) follows a status read (address 2) that returned bit 5 (inbound empty) as 0. While bit 5 reads 1, the status read is repeated.
- R4: The 16-byte message is read byte by byte. If byte 0 is not 0x96 or byte 1 is not 0x35, the run ends at once with code 2 and no further data reads.
- R5: If the 16 message bytes are not all read within POR_MS ticks after the second reset write completes, the run ends with code 1.
- R6: Each data-port write follows a status read that returned bit 6 (outbound full) as 0. While bit 6 reads 1, the status read is repeated.
- R7: Firmware bytes are written to address 0 in stream order, in blocks of BLK_BYTES. Byte 0 of the first block must be 0x3C; otherwise the run ends with code 3 and that byte is not written. Byte 1 of the first block gives the number N of further blocks, so (N+1)*BLK_BYTES bytes are written in total.
- R8: The block timer restarts at the start of each block. The first block must finish within FIRST_MS ticks, or the run ends with code 4. Each later block must finish within LATER_MS ticks, or the run ends with code 5.
- R9: After the last firmware byte, a status-gated read returns the verdict byte. 0xC3 ends the run with `error`=0 and code 0, 0x5A ends it with code 7, and any other value ends it with code 8.
- R10: If the verdict byte is not read within VERDICT_MS ticks after the last firmware write completes, the run ends with code 6.
- R11: The block never asserts `bus_rd` and `bus_wr` together. Each access holds its strobe and address until `bus_ready`. While `done` is high there are no bus accesses. `error` is `done` with a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a bring-up run when idle or finished |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_addr | output | 3 | Register offset of the current access |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes in this cycle |
| fw_data | input | 8 | Next firmware byte |
| fw_valid | input | 1 | fw_data holds a byte |
| fw_ready | output | 1 | Byte on fw_data is taken this cycle |
| done | output | 1 | Run finished (success or failure) |
| error | output | 1 | Run finished with a failure |
| err_code | output | 4 | Result code, 0 on success |

## Verification
A phase counter that drifts out of step shows at the ports within one access. Examples are a data read with no preceding empty-clear status, a byte written out of stream order, or a 17th message read. A timer that fails to restart per block shows only on a download that is longer than LATER_MS in total but shorter in each block: such a run falsely ends with code 5 some milliseconds into the second or third block. A wrong identity comparison shows as either a full 16-byte read where one or two reads were expected, or an early code 2 on a good message.

// File: rtl/boot_pkg.sv
// Shared constants and state type for the board bring-up sequencer.
// Assumes a byte-wide register map: data at 0, status at 2, reset at 7.
package boot_pkg;

    localparam logic [2:0] ADDR_DATA   = 3'd0;
    localparam logic [2:0] ADDR_STAT   = 3'd2;
    localparam logic [2:0] ADDR_RESET  = 3'd7;

    localparam int IN_EMPTY_BIT  = 5;
    localparam int OUT_FULL_BIT  = 6;

    localparam int         MSG_LEN    = 16;
    localparam logic [7:0] ID_BYTE0   = 8'h96;
    localparam logic [7:0] ID_BYTE1   = 8'h35;
    localparam logic [7:0] FW_MARKER  = 8'h3C;
    localparam logic [7:0] VERDICT_OK = 8'hC3;
    localparam logic [7:0] VERDICT_CRC = 8'h5A;

    localparam logic [3:0] CODE_OK         = 4'd0;
    localparam logic [3:0] CODE_MSG_TIME   = 4'd1;
    localparam logic [3:0] CODE_ID_BAD     = 4'd2;
    localparam logic [3:0] CODE_HDR_BAD    = 4'd3;
    localparam logic [3:0] CODE_BLK0_TIME  = 4'd4;
    localparam logic [3:0] CODE_BLKN_TIME  = 4'd5;
    localparam logic [3:0] CODE_VER_TIME   = 4'd6;
    localparam logic [3:0] CODE_CRC        = 4'd7;
    localparam logic [3:0] CODE_VER_BAD    = 4'd8;

    typedef enum logic [3:0] {
        S_IDLE, S_RST1, S_GAP, S_RST2,
        S_MSG_STAT, S_MSG_DATA,
        S_FW_STAT, S_FW_FETCH, S_FW_DATA,
        S_VER_STAT, S_VER_DATA, S_DONE
    } seq_state_t;

endpackage

// File: rtl/boot_tick_timer.sv
// Counts millisecond tick pulses since the last clear, saturating at all-ones.
// Assumes ms_tick is a single-cycle pulse; a clear wins over a tick.
module boot_tick_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);

    // Tick counter with synchronous clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (clr)                       count <= '0;
        else if (tick && (count != '1))     count <= count + 1'b1;
    end

    // R8: a clear always restarts the count from zero
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/boot_bus_port.sv
// Drives one register access at a time on the host bus and holds it until ready.
// Assumes the requester issues only when busy is low; abort drops an access.
module boot_bus_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_rd,
    input  logic       issue_wr,
    input  logic [2:0] issue_addr,
    input  logic [7:0] issue_wdata,
    input  logic       abort,
    input  logic       bus_ready,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [2:0] bus_addr,
    output logic [7:0] bus_wdata,
    output logic       busy,
    output logic       ack
);

    assign busy = bus_rd | bus_wr;
    assign ack  = busy & bus_ready;

    // Strobe and address registers: set on issue, cleared on completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (abort || ack) begin
            bus_rd <= 1'b0;
            bus_wr <= 1'b0;
        end else if (!busy && (issue_rd || issue_wr)) begin
            bus_rd    <= issue_rd;
            bus_wr    <= issue_wr & ~issue_rd;
            bus_addr  <= issue_addr;
            bus_wdata <= issue_wdata;
        end
    end

    // R11: reads and writes are never driven together
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R11: a pending access holds strobe, address and data until ready
    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_ready && !abort) |=>
            (busy && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));

endmodule

// File: rtl/board_boot_seq.sv
// Board bring-up sequencer: double command reset, identity message check,
// blockwise firmware download and verdict decode, each phase under a tick deadline.
// Assumes BLK_BYTES >= 2 (header and count sit in the first block) and a
// one-cycle ms_tick pulse spaced at least three clocks apart.
module board_boot_seq
    import boot_pkg::*;
#(
    parameter int GAP_MS     = 50,
    parameter int MSG_MS     = 2000,
    parameter int FIRST_MS   = 1000,
    parameter int LATER_MS   = 100,
    parameter int VERDICT_MS = 100,
    parameter int BLK_BYTES  = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ms_tick,
    output logic [2:0] bus_addr,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    input  logic       bus_ready,
    input  logic [7:0] fw_data,
    input  logic       fw_valid,
    output logic       fw_ready,
    output logic       done,
    output logic       error,
    output logic [3:0] err_code
);

    localparam int MAX_A  = (GAP_MS > MSG_MS) ? GAP_MS : MSG_MS;
    localparam int MAX_B  = (FIRST_MS > LATER_MS) ? FIRST_MS : LATER_MS;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_MS = (MAX_C > VERDICT_MS) ? MAX_C : VERDICT_MS;
    localparam int TW     = $clog2(MAX_MS + 2);
    localparam int BW     = (BLK_BYTES > 2) ? $clog2(BLK_BYTES) : 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(BLK_BYTES - 1);
    localparam logic [3:0]    MSG_LAST = 4'(MSG_LEN - 1);

    seq_state_t     state, state_n;
    logic [3:0]     msg_idx;
    logic [BW-1:0]  byte_idx;
    logic [7:0]     blocks_left;
    logic           first_blk;
    logic [7:0]     wbyte;
    logic [3:0]     code_n;
    logic [TW-1:0]  tcnt;
    logic [TW-1:0]  lim;
    logic           timed, expired, tmr_clr;
    logic           issue_rd, issue_wr, busy, ack;
    logic [2:0]     issue_addr;
    logic           take_byte;

    // Phase deadline selection and expiry flag.
    always_comb begin
        timed = 1'b1;
        lim   = '0;
        unique case (state)
            S_MSG_STAT, S_MSG_DATA:            lim = TW'(MSG_MS);
            S_FW_STAT, S_FW_FETCH, S_FW_DATA:  lim = first_blk ? TW'(FIRST_MS) : TW'(LATER_MS);
            S_VER_STAT, S_VER_DATA:            lim = TW'(VERDICT_MS);
            default:                           timed = 1'b0;
        endcase
        expired = timed && (tcnt >= lim);
    end

    // Bus requests issued by the current state while no access is pending.
    always_comb begin
        issue_rd   = 1'b0;
        issue_wr   = 1'b0;
        issue_addr = ADDR_STAT;
        if (!busy && !expired) begin
            unique case (state)
                S_RST1, S_RST2: begin issue_wr = 1'b1; issue_addr = ADDR_RESET; end
                S_MSG_STAT, S_FW_STAT, S_VER_STAT: issue_rd = 1'b1;
                S_MSG_DATA, S_VER_DATA: begin issue_rd = 1'b1; issue_addr = ADDR_DATA; end
                S_FW_DATA: begin issue_wr = 1'b1; issue_addr = ADDR_DATA; end
                default: ;
            endcase
        end
    end

    assign fw_ready  = (state == S_FW_FETCH) && !expired;
    assign take_byte = fw_ready && fw_valid;

    // Next-state, timer-clear and result-code decision.
    always_comb begin
        state_n = state;
        tmr_clr = 1'b0;
        code_n  = err_code;
        unique case (state)
            S_IDLE, S_DONE: if (start) begin state_n = S_RST1; code_n = CODE_OK; end
            S_RST1: if (ack) begin state_n = S_GAP; tmr_clr = 1'b1; end
            S_GAP:  if (tcnt >= TW'(GAP_MS)) state_n = S_RST2;
            S_RST2: if (ack) begin state_n = S_MSG_STAT; tmr_clr = 1'b1; end
            S_MSG_STAT: if (ack && !bus_rdata[IN_EMPTY_BIT]) state_n = S_MSG_DATA;
            S_MSG_DATA: if (ack) begin
                if ((msg_idx == 4'd0 && bus_rdata != ID_BYTE0) ||
                    (msg_idx == 4'd1 && bus_rdata != ID_BYTE1)) begin
                    state_n = S_DONE; code_n = CODE_ID_BAD;
                end else if (msg_idx == MSG_LAST) begin
                    state_n = S_FW_STAT; tmr_clr = 1'b1;
                end else begin
                    state_n = S_MSG_STAT;
                end
            end
            S_FW_STAT: if (ack && !bus_rdata[OUT_FULL_BIT]) state_n = S_FW_FETCH;
            S_FW_FETCH: if (fw_valid) begin
                if (first_blk && byte_idx == '0 && fw_data != FW_MARKER) begin
                    state_n = S_DONE; code_n = CODE_HDR_BAD;
                end else begin
                    state_n = S_FW_DATA;
                end
            end
            S_FW_DATA: if (ack) begin
                if (byte_idx == LAST_IDX) begin
                    tmr_clr = 1'b1;
                    state_n = (blocks_left == 8'd0) ? S_VER_STAT : S_FW_STAT;
                end else begin
                    state_n = S_FW_STAT;
                end
            end
            S_VER_STAT: if (ack && !bus_rdata[IN_EMPTY_BIT]) state_n = S_VER_DATA;
            S_VER_DATA: if (ack) begin
                state_n = S_DONE;
                if (bus_rdata == VERDICT_OK)       code_n = CODE_OK;
                else if (bus_rdata == VERDICT_CRC) code_n = CODE_CRC;
                else                               code_n = CODE_VER_BAD;
            end
            default: ;
        endcase
        // A deadline overrides any progress made in the same cycle.
        if (expired) begin
            state_n = S_DONE;
            tmr_clr = 1'b0;
            unique case (state)
                S_MSG_STAT, S_MSG_DATA: code_n = CODE_MSG_TIME;
                S_VER_STAT, S_VER_DATA: code_n = CODE_VER_TIME;
                default: code_n = first_blk ? CODE_BLK0_TIME : CODE_BLKN_TIME;
            endcase
        end
    end

    // State, result code and download progress registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            err_code    <= CODE_OK;
            msg_idx     <= '0;
            byte_idx    <= '0;
            blocks_left <= '0;
            first_blk   <= 1'b1;
            wbyte       <= '0;
        end else begin
            state    <= state_n;
            err_code <= code_n;
            if ((state == S_IDLE || state == S_DONE) && start) begin
                msg_idx     <= '0;
                byte_idx    <= '0;
                blocks_left <= '0;
                first_blk   <= 1'b1;
            end
            if (state == S_MSG_DATA && ack && !expired)
                msg_idx <= msg_idx + 1'b1;
            if (take_byte) begin
                wbyte <= fw_data;
                if (first_blk && byte_idx == BW'(1))
                    blocks_left <= fw_data;
            end
            if (state == S_FW_DATA && ack && !expired) begin
                if (byte_idx == LAST_IDX) begin
                    byte_idx  <= '0;
                    first_blk <= 1'b0;
                    if (blocks_left != 8'd0) blocks_left <= blocks_left - 1'b1;
                end else begin
                    byte_idx <= byte_idx + 1'b1;
                end
            end
        end
    end

    assign done  = (state == S_DONE);
    assign error = done && (err_code != CODE_OK);

    boot_tick_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (ms_tick),
        .count (tcnt)
    );

    boot_bus_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_rd    (issue_rd),
        .issue_wr    (issue_wr),
        .issue_addr  (issue_addr),
        .issue_wdata ((state == S_FW_DATA) ? wbyte : 8'h00),
        .abort       (expired),
        .bus_ready   (bus_ready),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .ack         (ack)
    );

    // R11: no bus activity once the run has finished
    a_r11_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(bus_rd || bus_wr));

    // R2: the second reset is only reached after the full gap
    a_r2_gap_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RST2) |-> (tcnt >= TW'(GAP_MS)));

    // R4: a wrong first identity byte ends the run with the identity code
    a_r4_id_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MSG_DATA && ack && !expired && msg_idx == 4'd0 && bus_rdata != ID_BYTE0)
            |=> (done && err_code == CODE_ID_BAD));

    // R9: a success verdict finishes cleanly
    a_r9_success_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VER_DATA && ack && !expired && bus_rdata == VERDICT_OK)
            |=> (done && !error && err_code == CODE_OK));

    // R7: firmware is never written before the header byte was accepted
    a_r7_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA) |-> (state == S_FW_DATA));

endmodule

// File: tb/board_boot_seq_tb.sv
// Bench: a behavioural board model answers the bus, a stream source feeds firmware,
// and every clock the bus traffic is checked against the requirements.
module board_boot_seq_tb;

    localparam int GAP  = 5;
    localparam int MSGT = 40;
    localparam int FST  = 30;
    localparam int LTR  = 10;
    localparam int VRD  = 8;
    localparam int BLK  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ms_tick = 1'b0;
    logic [2:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h00;
    logic       bus_ready = 1'b0;
    logic [7:0] fw_data = 8'h00;
    logic       fw_valid = 1'b0;
    logic       fw_ready;
    logic       done, error;
    logic [3:0] err_code;

    board_boot_seq #(
        .GAP_MS(GAP), .MSG_MS(MSGT), .FIRST_MS(FST), .LATER_MS(LTR),
        .VERDICT_MS(VRD), .BLK_BYTES(BLK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .fw_data(fw_data), .fw_valid(fw_valid), .fw_ready(fw_ready),
        .done(done), .error(error), .err_code(err_code)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int ticks = 0;
    int cyc = 0;

    // Board model state
    logic [7:0] in_q[$];
    logic [7:0] fw_q[$];
    logic [7:0] exp_wr[$];
    int  lat = 0, wait_cnt = 0;
    int  empty_polls = 0, full_polls = 0, full_after = -1;
    bit  full_forever = 0, verdict_en = 0, ok_read = 0, ok_write = 0, fw_pend = 0;
    logic [7:0] verdict = 8'h00;
    int  total_bytes = 0, data_reads = 0, writes = 0, rst_cnt = 0;
    int  rst_t[2];

    task automatic check(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Performs the effect of one access as the board raises ready.
    task automatic serve();
        bit e, f;
        if (bus_rd && bus_addr == 3'd2) begin
            e = (in_q.size() == 0) || (empty_polls > 0);
            if (empty_polls > 0) empty_polls--;
            f = full_forever || (full_polls > 0);
            if (full_polls > 0) full_polls--;
            bus_rdata = {1'b0, f, e, 5'b0};
            ok_read = !e;
            ok_write = !f;
        end else if (bus_rd && bus_addr == 3'd0) begin
            check(ok_read, "R3 data read without empty-clear status", 0, 1);
            bus_rdata = (in_q.size() > 0) ? in_q.pop_front() : 8'hFF;
            data_reads++;
            ok_read = 0; ok_write = 0;
        end else if (bus_wr && bus_addr == 3'd0) begin
            check(ok_write, "R6 data write without full-clear status", 0, 1);
            if (exp_wr.size() == 0) check(0, "R7 unexpected firmware write", bus_wdata, -1);
            else begin
                logic [7:0] x;
                x = exp_wr.pop_front();
                check(bus_wdata == x, "R7 firmware byte order", bus_wdata, x);
            end
            writes++;
            if (writes == total_bytes && verdict_en) in_q.push_back(verdict);
            if (writes == full_after) full_forever = 1;
            ok_read = 0; ok_write = 0;
        end else if (bus_wr && bus_addr == 3'd7) begin
            if (rst_cnt < 2) rst_t[rst_cnt] = ticks;
            rst_cnt++;
            ok_read = 0; ok_write = 0;
        end else begin
            check(0, "R11 access to unexpected address", bus_addr, 0);
        end
    endtask

    // Millisecond tick source: one pulse every 20 clocks.
    initial begin
        forever begin
            repeat (19) @(negedge clk);
            #2 ms_tick = 1'b1; ticks++;
            @(negedge clk);
            #2 ms_tick = 1'b0;
        end
    end

    // Board responder, firmware source and per-clock bus checks.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (bus_rd && bus_wr) check(0, "R11 both strobes", 1, 0);
                if (done && (bus_rd || bus_wr)) check(0, "R11 access after done", 1, 0);
            end
            if (bus_ready) begin
                bus_ready = 1'b0;
                wait_cnt = 0;
            end else if (bus_rd || bus_wr) begin
                if (wait_cnt < lat) wait_cnt++;
                else begin serve(); bus_ready = 1'b1; end
            end else begin
                wait_cnt = 0;
            end
            if (fw_pend && fw_q.size() > 0) void'(fw_q.pop_front());
            fw_pend  = 0;
            fw_valid = (fw_q.size() > 0);
            fw_data  = fw_valid ? fw_q[0] : 8'h00;
            #1 fw_pend = fw_valid && fw_ready;
        end
    end

    // Sets up the board for one run.
    task automatic prep(input int lat_i, input int n_msg, input logic [7:0] m0, input logic [7:0] m1,
                        input int nmore, input logic [7:0] hdr, input bit ven, input logic [7:0] vb,
                        input int fa);
        in_q.delete(); fw_q.delete(); exp_wr.delete();
        lat = lat_i; empty_polls = 3; full_polls = 2; full_after = fa; full_forever = 0;
        verdict_en = ven; verdict = vb; data_reads = 0; writes = 0; rst_cnt = 0;
        ok_read = 0; ok_write = 0;
        for (int i = 0; i < n_msg; i++)
            in_q.push_back(i == 0 ? m0 : (i == 1 ? m1 : 8'(i * 13 + 1)));
        total_bytes = (nmore + 1) * BLK;
        for (int i = 0; i < total_bytes; i++) begin
            logic [7:0] b;
            b = (i == 0) ? hdr : ((i == 1) ? 8'(nmore) : 8'(i * 7 + 3));
            fw_q.push_back(b);
            if (!(i == 0 && hdr != 8'h3C)) exp_wr.push_back(b);
        end
        if (hdr != 8'h3C) exp_wr.delete();
    endtask

    // Starts a run and waits for done; a hung run counts as a failure.
    task automatic run(output bit ok);
        int n;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        ok = done;
        if (!ok) check(0, "watchdog: run never finished", n, 20000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        bit ok;
        repeat (4) @(negedge clk);
        check(!bus_rd && !bus_wr && !done && !error && err_code == 0 && !fw_ready,
              "R1 state during reset", {bus_rd, bus_wr, done, error}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!bus_rd && !bus_wr && !done && !error && err_code == 0,
              "R1 idle after reset release", {bus_rd, bus_wr, done}, 0);

        // Success with five blocks: total longer than LATER but each block shorter (R8 restart).
        prep(1, 16, 8'h96, 8'h35, 4, 8'h3C, 1, 8'hC3, -1);
        run(ok);
        check(rst_cnt == 2, "R2 two reset writes", rst_cnt, 2);
        check(rst_t[1] - rst_t[0] >= GAP && rst_t[1] - rst_t[0] <= GAP + 1,
              "R2 gap between resets", rst_t[1] - rst_t[0], GAP);
        check(data_reads == 17, "R4 sixteen message reads plus verdict", data_reads, 17);
        check(writes == 5 * BLK, "R7 total bytes written", writes, 5 * BLK);
        check(done && !error && err_code == 0, "R9 success verdict", err_code, 0);
        check(exp_wr.size() == 0, "R8 all blocks accepted after timer restarts", exp_wr.size(), 0);

        prep(0, 16, 8'h96, 8'h35, 0, 8'h3C, 1, 8'h5A, -1);
        run(ok);
        check(error && err_code == 7, "R9 CRC verdict", err_code, 7);

        prep(0, 16, 8'h96, 8'h35, 1, 8'h3C, 1, 8'h77, -1);
        run(ok);
        check(error && err_code == 8, "R9 invalid verdict", err_code, 8);
        check(writes == 2 * BLK, "R7 one extra block from count byte", writes, 2 * BLK);

        prep(0, 16, 8'h97, 8'h35, 0, 8'h3C, 1, 8'hC3, -1);
        run(ok);
        check(error && err_code == 2, "R4 first identity byte wrong", err_code, 2);
        check(data_reads == 1, "R4 stop after first byte", data_reads, 1);

        prep(0, 16, 8'h96, 8'h53, 0, 8'h3C, 1, 8'hC3, -1);
        run(ok);
        check(err_code == 2, "R4 second identity byte wrong", err_code, 2);
        check(data_reads == 2 && writes == 0, "R4 stop after second byte", data_reads, 2);

        prep(0, 10, 8'h96, 8'h35, 0, 8'h3C, 1, 8'hC3, -1);
        run(ok);
        check(err_code == 1, "R5 message timeout", err_code, 1);
        check(data_reads == 10, "R5 reads before timeout", data_reads, 10);

        prep(0, 16, 8'h96, 8'h35, 0, 8'h3D, 1, 8'hC3, -1);
        run(ok);
        check(err_code == 3, "R7 bad header code", err_code, 3);
        check(writes == 0, "R7 bad header not written", writes, 0);

        prep(0, 16, 8'h96, 8'h35, 2, 8'h3C, 1, 8'hC3, 3);
        run(ok);
        check(err_code == 4, "R8 first block timeout", err_code, 4);
        check(writes == 3, "R6 no write while full", writes, 3);

        prep(0, 16, 8'h96, 8'h35, 1, 8'h3C, 1, 8'hC3, BLK + 2);
        run(ok);
        check(err_code == 5, "R8 later block timeout", err_code, 5);

        prep(0, 16, 8'h96, 8'h35, 0, 8'h3C, 0, 8'hC3, -1);
        run(ok);
        check(err_code == 6, "R10 verdict timeout", err_code, 6);
        repeat (20) @(negedge clk);
        check(done && !bus_rd && !bus_wr, "R11 quiet after failure", {bus_rd, bus_wr}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Overall watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule